// File: doc/BRIEF.md
# Four-Slot Wait-Free Pool Buffer

This block passes a stream of data words from one writer to one reader, and neither side ever stalls the other. It behaves as a pool: the reader always gets a recent, fully written item. Some items may never be read, and the same item may be read more than once. Storage is four data slots, organised as two banks of two. A few one-bit control registers steer each access. The writer picks a bank that differs from the one the reader holds. Within a bank, a per-bank toggle bit names the slot that was written most recently.

Each side runs a fixed three-step sequence, one step per clock cycle, started by a request pulse.

The writer sequence is:
1. Store the word into the free slot of its target bank.
2. Flip that bank's toggle bit.
3. Publish the bank as the latest one, and choose the next target bank as the complement of the reader's bank.

The reader sequence is:
1. Latch the latest bank.
2. Copy both toggle bits.
3. Register the selected slot onto its output and raise its acknowledge.

When steps of the two sequences meet on the same edge, the reader's step counts as having happened first.

Top module: `pool4_buf`

## Requirements
- R1: While reset is active, and after it is released, `wr_ack` and `rd_ack` are 0 and `rd_data` equals `INIT_VAL`. A read made before any write returns `INIT_VAL`.
- R2: A write is accepted on a rising edge where `wr_req` is 1 and the writer is idle. `wr_ack` is 1 for exactly one cycle, set on the third rising edge counting the accepting edge as the first.
- R3: A read is accepted on a rising edge where `rd_req` is 1 and the reader is idle. `rd_ack` is 1 for exactly one cycle, set on the third rising edge counting the accepting edge as the first. In that cycle `rd_data` carries the item. `rd_data` changes only in a cycle where `rd_ack` is 1.
- R4: A request held or repeated while its side is busy is ignored. A request held high for three cycles yields exactly one acknowledge, and acknowledges of one side are at least three cycles apart.
- R5: Every word returned on `rd_data` equals, in all bits, either the word of one accepted write or `INIT_VAL`. It is never a mix of two writes, even when reads and writes overlap in any phase.
- R6: A read returns the item of the latest write whose acknowledge edge came strictly before the read's accepting edge, or the item of a later write.
- R7: A read that overlaps no write returns exactly the item of the most recent acknowledged write.
- R8: The slot being stored by the writer is never the slot being delivered by the reader on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write request, sampled while the writer is idle |
| wr_data | input | DATA_W | Word to store, sampled on the accepting edge |
| wr_ack | output | 1 | One-cycle pulse: the write is published |
| rd_req | input | 1 | Read request, sampled while the reader is idle |
| rd_data | output | DATA_W | Item delivered by the last read |
| rd_ack | output | 1 | One-cycle pulse: `rd_data` holds a fresh item |

## Verification
Three pairs of events can land on the same clock edge:
- The writer's publish step and the reader's bank-latch step.
- The writer's toggle flip and the reader's toggle copy.
- The writer's slot store and the reader's slot delivery.

The bench provokes all of these. It runs the writer and the reader concurrently with random gaps of zero to three cycles, so every phase offset between the two sequences occurs many times.

Every written word carries a unique sequence number in its low bits. Each returned word is judged two ways:
- For coherence, it is matched against the full word stored for that sequence number.
- For freshness, its number is compared with the last write acknowledged before the read was accepted.

// File: rtl/pool4_pkg.sv
package pool4_pkg;

  localparam int unsigned NUM_BANKS      = 2;
  localparam int unsigned SLOTS_PER_BANK = 2;
  localparam int unsigned NUM_SLOTS      = NUM_BANKS * SLOTS_PER_BANK;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_FLIP = 2'd1,
    W_PUB  = 2'd2
  } wr_state_e;

  typedef enum logic [1:0] {
    R_IDLE = 2'd0,
    R_COPY = 2'd1,
    R_OUT  = 2'd2
  } rd_state_e;

  typedef struct packed {
    logic bank;
    logic idx;
  } slot_addr_t;

endpackage

// File: rtl/pool4_slots.sv
module pool4_slots
  import pool4_pkg::*;
#(
  parameter int unsigned     DATA_W   = 32,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  slot_addr_t        waddr,
  input  logic [DATA_W-1:0] wdata,
  input  slot_addr_t        raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    logic              en;

    assign en = we && (waddr == slot_addr_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= INIT_VAL;
      end else if (en) begin
        q <= wdata;
      end
    end

    assign slot_q[g] = q;
  end

  assign rdata = slot_q[raddr];

endmodule

// File: rtl/pool4_wr_seq.sv
module pool4_wr_seq
  import pool4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic       rd_bank,
  input  logic       rd_take,
  output logic [1:0] toggles,
  output logic       last_bank,
  output logic       store_en,
  output slot_addr_t store_addr,
  output logic       wr_ack
);

  wr_state_e  st_q, st_d;
  logic       next_q, next_d;
  logic       last_q, last_d;
  logic [1:0] tog_q, tog_d;
  logic       ack_q, ack_d;
  logic       rd_bank_eff;

  // When the reader latches its bank on the same edge, the reader is ordered
  // first, so the bank it is about to hold is the one to avoid.
  assign rd_bank_eff = rd_take ? last_q : rd_bank;

  always_comb begin
    st_d   = st_q;
    next_d = next_q;
    last_d = last_q;
    tog_d  = tog_q;
    ack_d  = 1'b0;
    unique case (st_q)
      W_IDLE: begin
        if (wr_req) st_d = W_FLIP;
      end
      W_FLIP: begin
        tog_d[next_q] = ~tog_q[next_q];
        st_d          = W_PUB;
      end
      W_PUB: begin
        last_d = next_q;
        next_d = ~rd_bank_eff;
        ack_d  = 1'b1;
        st_d   = W_IDLE;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      next_q <= 1'b0;
      last_q <= 1'b0;
      tog_q  <= 2'b00;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      next_q <= next_d;
      last_q <= last_d;
      tog_q  <= tog_d;
      ack_q  <= ack_d;
    end
  end

  assign store_en        = (st_q == W_IDLE) && wr_req;
  assign store_addr.bank = next_q;
  assign store_addr.idx  = ~tog_q[next_q];
  assign toggles         = tog_q;
  assign last_bank       = last_q;
  assign wr_ack          = ack_q;

endmodule

// File: rtl/pool4_rd_seq.sv
module pool4_rd_seq
  import pool4_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              last_bank,
  input  logic [1:0]        toggles,
  input  logic [DATA_W-1:0] slot_data,
  output logic              rd_take,
  output logic              rd_bank,
  output logic              deliver,
  output slot_addr_t        sel_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack
);

  rd_state_e         st_q, st_d;
  logic              bank_q, bank_d;
  logic [1:0]        view_q, view_d;
  logic              ack_q, ack_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  always_comb begin
    st_d   = st_q;
    bank_d = bank_q;
    view_d = view_q;
    ack_d  = 1'b0;
    unique case (st_q)
      R_IDLE: begin
        if (rd_req) begin
          bank_d = last_bank;
          st_d   = R_COPY;
        end
      end
      R_COPY: begin
        view_d = toggles;
        st_d   = R_OUT;
      end
      R_OUT: begin
        ack_d = 1'b1;
        st_d  = R_IDLE;
      end
      default: st_d = R_IDLE;
    endcase
  end

  assign data_en = (st_q == R_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= R_IDLE;
      bank_q <= 1'b0;
      view_q <= 2'b00;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bank_q <= bank_d;
      view_q <= view_d;
      ack_q  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= INIT_VAL;
    end else if (data_en) begin
      data_q <= slot_data;
    end
  end

  assign rd_take       = (st_q == R_IDLE) && rd_req;
  assign rd_bank       = bank_q;
  assign deliver       = data_en;
  assign sel_addr.bank = bank_q;
  assign sel_addr.idx  = view_q[bank_q];
  assign rd_data       = data_q;
  assign rd_ack        = ack_q;

endmodule

// File: rtl/pool4_buf.sv
module pool4_buf
  import pool4_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] INIT_VAL = '0,
  parameter int unsigned       SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack
);

  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[SYNC_LEN-1];

  logic              wr_store;
  slot_addr_t        wr_addr;
  logic [1:0]        toggles;
  logic              last_bank;
  logic              rd_take;
  logic              rd_bank;
  logic              rd_out;
  slot_addr_t        rd_addr;
  logic [DATA_W-1:0] slot_rdata;

  pool4_wr_seq u_wr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_req     (wr_req),
    .rd_bank    (rd_bank),
    .rd_take    (rd_take),
    .toggles    (toggles),
    .last_bank  (last_bank),
    .store_en   (wr_store),
    .store_addr (wr_addr),
    .wr_ack     (wr_ack)
  );

  pool4_rd_seq #(
    .DATA_W   (DATA_W),
    .INIT_VAL (INIT_VAL)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_req    (rd_req),
    .last_bank (last_bank),
    .toggles   (toggles),
    .slot_data (slot_rdata),
    .rd_take   (rd_take),
    .rd_bank   (rd_bank),
    .deliver   (rd_out),
    .sel_addr  (rd_addr),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack)
  );

  pool4_slots #(
    .DATA_W   (DATA_W),
    .INIT_VAL (INIT_VAL)
  ) u_slots (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (wr_store),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (slot_rdata)
  );

endmodule

// File: rtl/pool4_chk.sv
module pool4_chk
  import pool4_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              wr_ack,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_store,
  input slot_addr_t        wr_addr,
  input logic              rd_out,
  input slot_addr_t        rd_addr
);

  a_r2_wr_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);

  a_r2_wr_ack_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(wr_req, 3));

  a_r3_rd_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  a_r3_rd_ack_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(rd_req, 3));

  a_r3_rd_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> rd_ack);

  a_r4_rd_ack_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (!$past(rd_ack, 1) && !$past(rd_ack, 2)));

  a_r4_wr_ack_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> (!$past(wr_ack, 1) && !$past(wr_ack, 2)));

  a_r8_slot_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_store && rd_out) |-> (wr_addr != rd_addr));

endmodule

bind pool4_buf pool4_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_req   (wr_req),
  .wr_ack   (wr_ack),
  .rd_req   (rd_req),
  .rd_ack   (rd_ack),
  .rd_data  (rd_data),
  .wr_store (wr_store),
  .wr_addr  (wr_addr),
  .rd_out   (rd_out),
  .rd_addr  (rd_addr)
);

// File: tb/pool4_buf_tb.sv
module pool4_buf_tb;

  localparam int unsigned DW    = 32;
  localparam logic [DW-1:0] INIT = '0;
  localparam int unsigned HDEP  = 1024;
  localparam int unsigned NRAND = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ack;
  logic          rd_req = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_ack;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] hist [HDEP];
  int wseq      = 0;
  int cur_w     = 0;
  int last_pub  = 0;
  int rd_snap   = 0;
  int wr_acks   = 0;
  int rd_acks   = 0;
  int n_rd_chk  = 0;

  always #4 clk = ~clk;

  pool4_buf #(.DATA_W(DW), .INIT_VAL(INIT)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_data (wr_data),
    .wr_ack  (wr_ack),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .rd_ack  (rd_ack)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_word(input int seq);
    logic [15:0] hi;
    hi = 16'($urandom);
    return {hi, 16'(seq)};
  endfunction

  // Coherence (R5) and freshness (R6) judged on every delivered item.
  always @(negedge clk) begin
    if (rst_n && wr_ack) begin
      wr_acks++;
      last_pub = cur_w;
    end
    if (rst_n && rd_ack) begin
      int s;
      rd_acks++;
      n_rd_chk++;
      s = int'(rd_data[15:0]);
      check((s <= wseq) && (rd_data == hist[s]), "R5 coherent item", rd_data,
            (s <= wseq) ? hist[s] : '0);
      check(s >= rd_snap, "R6 freshness", DW'(s), DW'(rd_snap));
    end
  end

  // Returns the negedge index of the first acknowledge (0 if none).
  task automatic do_write(input int hold, output int ack_at);
    int cyc;
    bit seen;
    wseq++;
    hist[wseq] = mk_word(wseq);
    @(negedge clk);
    #2;
    cur_w   = wseq;
    wr_data = hist[wseq];
    wr_req  = 1'b1;
    cyc = 0; seen = 1'b0; ack_at = 0;
    while (!(seen && cyc >= hold) && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (wr_ack && !seen) begin seen = 1'b1; ack_at = cyc; end
      if (cyc == hold) begin #2; wr_req = 1'b0; end
    end
  endtask

  task automatic do_read(input int hold, output int ack_at);
    int cyc;
    bit seen;
    @(negedge clk);
    #2;
    rd_snap = last_pub;
    rd_req  = 1'b1;
    cyc = 0; seen = 1'b0; ack_at = 0;
    while (!(seen && cyc >= hold) && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (rd_ack && !seen) begin seen = 1'b1; ack_at = cyc; end
      if (cyc == hold) begin #2; rd_req = 1'b0; end
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int at;
    int base;
    logic [DW-1:0] held;
    void'($urandom(32'd20240611));
    hist[0] = INIT;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(wr_ack == 1'b0, "R1 wr_ack in reset", DW'(wr_ack), '0);
    check(rd_ack == 1'b0, "R1 rd_ack in reset", DW'(rd_ack), '0);
    check(rd_data == INIT, "R1 rd_data in reset", rd_data, INIT);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wr_ack == 1'b0 && rd_ack == 1'b0, "R1 acks after release",
          DW'({wr_ack, rd_ack}), '0);

    // R1: read before any write
    do_read(1, at);
    check(rd_data == INIT, "R1 first read returns init", rd_data, INIT);
    check(at == 3, "R3 read ack latency", DW'(at), 32'd3);

    // R2 / R7: single write, then quiet read
    do_write(1, at);
    check(at == 3, "R2 write ack latency", DW'(at), 32'd3);
    @(negedge clk);
    check(wr_ack == 1'b0, "R2 write ack single cycle", DW'(wr_ack), '0);
    do_read(1, at);
    check(rd_data == hist[wseq], "R7 quiet read latest", rd_data, hist[wseq]);

    // R3: output held between acknowledges
    held = rd_data;
    repeat (5) @(negedge clk);
    check(rd_data == held, "R3 rd_data held", rd_data, held);

    // R7: two writes back to back, read returns the second
    do_write(1, at);
    do_write(1, at);
    do_read(1, at);
    check(rd_data == hist[wseq], "R7 latest of two", rd_data, hist[wseq]);

    // R4: held requests produce one acknowledge each
    base = wr_acks;
    do_write(3, at);
    repeat (6) @(negedge clk);
    check(wr_acks - base == 1, "R4 held write one ack", DW'(wr_acks - base), 32'd1);
    base = rd_acks;
    do_read(3, at);
    repeat (6) @(negedge clk);
    check(rd_acks - base == 1, "R4 held read one ack", DW'(rd_acks - base), 32'd1);
    check(rd_data == hist[wseq], "R4 held write stored once", rd_data, hist[wseq]);

    // R5 / R6 / R8: concurrent random traffic at every phase offset
    fork
      begin
        for (int i = 0; i < NRAND; i++) begin
          repeat ($urandom % 4) @(negedge clk);
          do_write(1, at);
        end
      end
      begin
        for (int i = 0; i < NRAND; i++) begin
          int a2;
          repeat ($urandom % 4) @(negedge clk);
          do_read(1, a2);
        end
      end
    join

    // R7: quiet read after the storm
    repeat (4) @(negedge clk);
    do_read(1, at);
    check(rd_data == hist[wseq], "R7 final quiet read", rd_data, hist[wseq]);
    check(n_rd_chk > NRAND, "R5 reads observed", DW'(n_rd_chk), DW'(NRAND));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule